// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine

The engine accepts an incoming frame as a byte stream, together with its length announced on the first byte, and spreads the bytes over receive buffers described by a linked chain of four-word descriptors in memory. Each descriptor supplies an ownership flag, a buffer size, a buffer address and a link to the next descriptor. For every descriptor it fills, the engine writes back a fresh status word that carries the reported length and the first and last flags. It signals receive-done and buffer-unavailable events as one-cycle pulses that a surrounding interrupt-status register can collect. It also emits a one-cycle request to clear the DMA-start control bit when a frame ends.

Software loads the list head, which also sets the current pointer, and then sets the receive enable. Each frame's search for a first buffer begins at the current pointer. After each filled buffer the engine follows the link. If the chain runs dry, the engine falls back to the list head and drops whatever remains of the frame. Address filtering, FCS checking and error detection are not part of this block.

Top module: `rxs_engine`

## Requirements
- R1: A pulse on `head_wr` loads `head_addr` into both the list head and the current pointer, and `cur_desc_ptr` shows the new value one cycle later.
- R2: A frame that starts while `rx_en` is low is consumed from the stream. It causes no memory access, no pulse on any event output, and no change of `cur_desc_ptr`.
- R3: A descriptor is usable when status bit 31 is set and status2 bits 10:0 are at least 64. The search for a frame's first buffer starts at the current pointer and follows the links past unusable entries. It gives up when the current pointer is 0, or when a link equals the search start, or when a link is 0. On giving up it pulses `int_nobuf_set` once, drops the whole frame, and leaves the current pointer unchanged.
- R4: Let `left` be the number of frame bytes not yet stored. If the buffer size is below `left`+4, the engine stores min(size, `left`) bytes and reports the buffer size. Otherwise it stores `left` bytes and reports `left`+4, plus (64−`left`) when `left` is below 64, and marks the descriptor as last.
- R5: After the bytes of a descriptor are stored, the engine writes a status word to that descriptor's address. The word holds the reported length in bits 29:16, bit 9 set only on the frame's first descriptor, bit 8 set on the last one, and every other bit zero. This clears the ownership bit and any error bits.
- R6: Each status write-back is accompanied by an `int_rx_set` pulse, unless status2 bit 31 of that descriptor is set.
- R7: After each write-back the engine examines the linked descriptor. If it is not usable, or the link is 0, the engine pulses `int_nobuf_set`, reloads the current pointer from the list head, and consumes and discards the rest of the frame.
- R8: Every frame that starts while `rx_en` is high ends with exactly one single-cycle pulse on `dma_start_clr`.
- R9: When the linked descriptor is usable, it becomes the current pointer, even if the frame has no bytes left.
- R10: Descriptor words are little-endian 32-bit values at +0 (status), +4 (status2), +8 (buffer address) and +12 (link). Frame bytes are written to consecutive ascending byte addresses from the buffer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| head_wr | input | 1 | Load list head and current pointer |
| head_addr | input | AW | Address loaded by `head_wr` |
| cur_desc_ptr | output | AW | Current descriptor pointer |
| frm_valid | input | 1 | Stream byte valid |
| frm_sof | input | 1 | Marks the first byte of a frame |
| frm_len | input | LEN_W | Frame length in bytes (at least 1), valid with `frm_sof` |
| frm_data | input | 8 | Stream byte |
| frm_ready | output | 1 | Stream byte accepted when high with `frm_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_byte | output | 1 | Write is a single byte in `mem_wdata[7:0]` |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| int_rx_set | output | 1 | Receive-done event pulse |
| int_nobuf_set | output | 1 | Buffer-unavailable event pulse |
| dma_start_clr | output | 1 | End-of-frame request to clear the DMA-start bit |

## Verification
The properties assume that memory answers every read with fixed one-cycle latency and never stalls. They assume that `frm_len` is non-zero and stays stable on the start byte, and that `head_wr` is only pulsed while no frame is in progress. The bench memory model always returns data in the cycle after the request, and it builds every frame with a length of at least 1. It loads the head only between frames, after the previous frame has fully drained. Descriptor rings are set up so that every search ends either at a usable entry or at a link back to its start.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned OWN_BIT     = 31;
  localparam int unsigned NOIRQ_BIT   = 31;
  localparam int unsigned FIRST_BIT   = 9;
  localparam int unsigned LAST_BIT    = 8;
  localparam int unsigned LEN_LO      = 16;
  localparam int unsigned LEN_FIELD_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EVAL,
    ST_FILL,
    ST_WB,
    ST_DROP,
    ST_DONE
  } rxs_state_e;

  // word 3 .. word 0 of a descriptor
  typedef struct packed {
    logic [31:0] link;
    logic [31:0] bufp;
    logic [31:0] ctl2;
    logic [31:0] ctl;
  } rxs_desc_t;

endpackage

// File: rtl/rxs_desc_fetch.sv
module rxs_desc_fetch
  import rxs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          done,
  output rxs_desc_t     desc
);

  localparam int IDX_W = $clog2(DESC_WORDS + 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    base_q, base_d;
  logic [31:0]      word_q [DESC_WORDS];
  logic [31:0]      word_d [DESC_WORDS];

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    base_d   = base_q;
    word_d   = word_q;
    rd_req   = 1'b0;
    done     = 1'b0;
    if (!active_q) begin
      if (go) begin
        active_d = 1'b1;
        idx_d    = '0;
        base_d   = base;
      end
    end else begin
      if (int'(idx_q) < DESC_WORDS) rd_req = 1'b1;
      if (idx_q != '0) word_d[int'(idx_q) - 1] = rd_data;
      if (int'(idx_q) == DESC_WORDS) begin
        active_d = 1'b0;
        done     = 1'b1;
      end
      idx_d = idx_q + 1'b1;
    end
  end

  assign rd_addr = base_q + (AW'(idx_q) << 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      for (int k = 0; k < DESC_WORDS; k++) word_q[k] <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      base_q   <= base_d;
      for (int k = 0; k < DESC_WORDS; k++) word_q[k] <= word_d[k];
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_pack
    assign desc[g*32 +: 32] = word_q[g];
  end

endmodule

// File: rtl/rxs_status_fmt.sv
module rxs_status_fmt
  import rxs_pkg::*;
#(
  parameter int LEN_W     = 14,
  parameter int SIZE_W    = 11,
  parameter int MIN_FRAME = 64,
  parameter int FCS_LEN   = 4
) (
  input  logic [SIZE_W-1:0] buf_size,
  input  logic [LEN_W-1:0]  left,
  input  logic              first,
  output logic [SIZE_W-1:0] take,
  output logic              is_last,
  output logic [31:0]       status
);

  localparam int EW = LEN_W + 2;

  logic [EW-1:0] left_x, size_x, need_x, pad_x, rep_x;

  always_comb begin
    left_x  = EW'(left);
    size_x  = EW'(buf_size);
    need_x  = left_x + EW'(FCS_LEN);
    is_last = (size_x >= need_x);
    pad_x   = (left_x < EW'(MIN_FRAME)) ? (EW'(MIN_FRAME) - left_x) : '0;
    if (is_last)              take = SIZE_W'(left);
    else if (size_x < left_x) take = buf_size;
    else                      take = SIZE_W'(left);
    rep_x = is_last ? (need_x + pad_x) : size_x;
    status = '0;
    status[LEN_LO +: LEN_FIELD_W] = LEN_FIELD_W'(rep_x);
    status[FIRST_BIT] = first;
    status[LAST_BIT]  = is_last;
  end

endmodule

// File: rtl/rxs_engine.sv
module rxs_engine
  import rxs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 14,
  parameter int SIZE_W    = 11,
  parameter int MIN_BUF   = 64,
  parameter int MIN_FRAME = 64,
  parameter int FCS_LEN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             head_wr,
  input  logic [AW-1:0]    head_addr,
  output logic [AW-1:0]    cur_desc_ptr,
  input  logic             frm_valid,
  input  logic             frm_sof,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [7:0]       frm_data,
  output logic             frm_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_byte,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             int_rx_set,
  output logic             int_nobuf_set,
  output logic             dma_start_clr
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  rxs_state_e        state_q, state_d;
  logic [AW-1:0]     head_q, head_d, cur_q, cur_d, start_q, start_d, daddr_q, daddr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              first_q, first_d, chain_q, chain_d, en_q, en_d;

  logic              fetch_go, f_req, f_done;
  logic [AW-1:0]     fetch_base, f_addr;
  rxs_desc_t         desc;
  logic [SIZE_W-1:0] take;
  logic              is_last;
  logic [31:0]       status_w;
  logic [SIZE_W-1:0] buf_size;
  logic [AW-1:0]     link_a, bufp_a;
  logic              usable;

  rxs_desc_fetch #(.AW(AW)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .go      (fetch_go),
    .base    (fetch_base),
    .rd_req  (f_req),
    .rd_addr (f_addr),
    .rd_data (mem_rdata),
    .done    (f_done),
    .desc    (desc)
  );

  assign buf_size = desc.ctl2[SIZE_W-1:0];
  assign link_a   = desc.link[AW-1:0];
  assign bufp_a   = desc.bufp[AW-1:0];
  assign usable   = desc.ctl[OWN_BIT] && (buf_size >= SIZE_W'(MIN_BUF));

  rxs_status_fmt #(
    .LEN_W(LEN_W), .SIZE_W(SIZE_W), .MIN_FRAME(MIN_FRAME), .FCS_LEN(FCS_LEN)
  ) u_fmt (
    .buf_size (buf_size),
    .left     (left_q),
    .first    (first_q),
    .take     (take),
    .is_last  (is_last),
    .status   (status_w)
  );

  always_comb begin
    state_d = state_q;  head_d  = head_q;   cur_d   = cur_q;
    start_d = start_q;  daddr_d = daddr_q;  left_d  = left_q;
    first_d = first_q;  chain_d = chain_q;  en_d    = en_q;
    cnt_d   = cnt_q;
    fetch_go   = 1'b0;
    fetch_base = link_a;
    frm_ready  = 1'b0;
    mem_req    = f_req;
    mem_we     = 1'b0;
    mem_byte   = 1'b0;
    mem_addr   = f_addr;
    mem_wdata  = '0;
    int_rx_set    = 1'b0;
    int_nobuf_set = 1'b0;
    dma_start_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (frm_valid && frm_sof) begin
          left_d  = frm_len;
          first_d = 1'b1;
          chain_d = 1'b0;
          en_d    = rx_en;
          if (!rx_en) begin
            state_d = ST_DROP;
          end else if (cur_q == '0) begin
            int_nobuf_set = 1'b1;
            state_d       = ST_DROP;
          end else begin
            fetch_go   = 1'b1;
            fetch_base = cur_q;
            start_d    = cur_q;
            daddr_d    = cur_q;
            state_d    = ST_FETCH;
          end
        end
      end
      ST_FETCH: if (f_done) state_d = ST_EVAL;
      ST_EVAL: begin
        if (usable) begin
          cur_d   = daddr_q;
          cnt_d   = '0;
          state_d = (chain_q && left_q == '0) ? ST_DONE : ST_FILL;
        end else if (chain_q) begin
          int_nobuf_set = 1'b1;
          cur_d         = head_q;
          state_d       = ST_DROP;
        end else if (link_a == start_q || link_a == '0) begin
          int_nobuf_set = 1'b1;
          state_d       = ST_DROP;
        end else begin
          fetch_go = 1'b1;
          daddr_d  = link_a;
          state_d  = ST_FETCH;
        end
      end
      ST_FILL: begin
        frm_ready = 1'b1;
        if (frm_valid) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_byte  = 1'b1;
          mem_addr  = bufp_a + AW'(cnt_q);
          mem_wdata = {24'h0, frm_data};
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q + 1'b1 == take) state_d = ST_WB;
        end
      end
      ST_WB: begin
        mem_req    = 1'b1;
        mem_we     = 1'b1;
        mem_addr   = daddr_q;
        mem_wdata  = status_w;
        int_rx_set = !desc.ctl2[NOIRQ_BIT];
        left_d     = left_q - LEN_W'(take);
        first_d    = 1'b0;
        chain_d    = 1'b1;
        if (link_a == '0) begin
          int_nobuf_set = 1'b1;
          cur_d         = head_q;
          state_d       = ST_DROP;
        end else begin
          fetch_go = 1'b1;
          daddr_d  = link_a;
          state_d  = ST_FETCH;
        end
      end
      ST_DROP: begin
        frm_ready = (left_q != '0);
        if (left_q == '0)   state_d = en_q ? ST_DONE : ST_IDLE;
        else if (frm_valid) left_d  = left_q - 1'b1;
      end
      ST_DONE: begin
        dma_start_clr = 1'b1;
        state_d       = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (head_wr) begin
      head_d = head_addr;
      cur_d  = head_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      head_q  <= '0;  cur_q   <= '0;
      start_q <= '0;  daddr_q <= '0;
      left_q  <= '0;  cnt_q   <= '0;
      first_q <= 1'b0; chain_q <= 1'b0; en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      head_q  <= head_d;  cur_q   <= cur_d;
      start_q <= start_d; daddr_q <= daddr_d;
      left_q  <= left_d;  cnt_q   <= cnt_d;
      first_q <= first_d; chain_q <= chain_d; en_q <= en_d;
    end
  end

  assign cur_desc_ptr = cur_q;

endmodule

// File: rtl/rxs_engine_chk.sv
module rxs_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          head_wr,
  input logic [AW-1:0] head_addr,
  input logic [AW-1:0] cur_desc_ptr,
  input logic          frm_valid,
  input logic          frm_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_byte,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          int_rx_set,
  input logic          dma_start_clr
);

  logic byte_wr, word_wr;
  assign byte_wr = mem_req && mem_we && mem_byte;
  assign word_wr = mem_req && mem_we && !mem_byte;

  p_head_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr |=> cur_desc_ptr == $past(head_addr));

  p_accept_is_byte_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && mem_req && mem_we) |-> mem_byte);

  p_status_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |-> (mem_wdata[31:30] == 2'b00 && mem_wdata[15:10] == 6'h0 && mem_wdata[7:0] == 8'h0));

  p_rx_event_on_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_rx_set |-> word_wr);

  p_end_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start_clr |=> !dma_start_clr);

  p_bytes_ascend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && $past(byte_wr)) |-> mem_addr == $past(mem_addr) + 1'b1);

endmodule

bind rxs_engine rxs_engine_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .head_wr       (head_wr),
  .head_addr     (head_addr),
  .cur_desc_ptr  (cur_desc_ptr),
  .frm_valid     (frm_valid),
  .frm_ready     (frm_ready),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_byte      (mem_byte),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .int_rx_set    (int_rx_set),
  .dma_start_clr (dma_start_clr)
);

// File: tb/tb_rxs_engine.sv
`timescale 1ns/1ps
module tb_rxs_engine;

  localparam int AW = 32;
  localparam int LEN_W = 14;

  logic             clk, rst_n, rx_en, head_wr;
  logic [AW-1:0]    head_addr, cur_desc_ptr;
  logic             frm_valid, frm_sof, frm_ready;
  logic [LEN_W-1:0] frm_len;
  logic [7:0]       frm_data;
  logic             mem_req, mem_we, mem_byte;
  logic [AW-1:0]    mem_addr;
  logic [31:0]      mem_wdata, mem_rdata;
  logic             int_rx_set, int_nobuf_set, dma_start_clr;

  rxs_engine dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .head_wr(head_wr), .head_addr(head_addr),
    .cur_desc_ptr(cur_desc_ptr), .frm_valid(frm_valid), .frm_sof(frm_sof), .frm_len(frm_len),
    .frm_data(frm_data), .frm_ready(frm_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .int_rx_set(int_rx_set), .int_nobuf_set(int_nobuf_set), .dma_start_clr(dma_start_clr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk, n_fail;
  int n_req, n_rx, n_nb, n_dc, n_wrb;
  int e_rx, e_nb, e_dc, e_wrb;
  int unsigned m_head, m_cur;
  bit [7:0] mem   [int unsigned];
  bit [7:0] exp_w [int unsigned];
  bit [7:0] fb [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic bit [31:0] mem_rd(input int unsigned a);
    bit [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mem.exists(a + k) ? mem[a + k] : 8'h0;
    return w;
  endfunction

  function automatic bit [31:0] view_rd(input int unsigned a);
    bit [31:0] w;
    for (int k = 0; k < 4; k++)
      w[8*k +: 8] = exp_w.exists(a + k) ? exp_w[a + k] : (mem.exists(a + k) ? mem[a + k] : 8'h0);
    return w;
  endfunction

  task automatic dut_wr_byte(input int unsigned a, input bit [7:0] d);
    check(exp_w.exists(a) && exp_w[a] == d, "R10", $sformatf("write @%0h", a),
          d, exp_w.exists(a) ? exp_w[a] : 9'h1ff);
    mem[a] = d;
    n_wrb++;
  endtask

  // memory model and event counters, compared on every clock
  always @(posedge clk) begin
    if (mem_req) begin
      n_req++;
      if (mem_we) begin
        if (mem_byte) dut_wr_byte(mem_addr, mem_wdata[7:0]);
        else for (int k = 0; k < 4; k++) dut_wr_byte(mem_addr + k, mem_wdata[8*k +: 8]);
      end else begin
        mem_rdata <= mem_rd(mem_addr);
      end
    end
    if (int_rx_set)    n_rx++;
    if (int_nobuf_set) n_nb++;
    if (dma_start_clr) n_dc++;
  end

  task automatic put_desc(input int unsigned a, input bit own, input int size, input bit noirq,
                          input int unsigned bufp, input int unsigned nxt);
    bit [31:0] w [4];
    w[0] = {own, 31'h0000_4093};   // stale error bits that a write-back must clear
    w[1] = {noirq, 20'h0, 11'(size)};
    w[2] = bufp;
    w[3] = nxt;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        mem[a + 4*i + k] = w[i][8*k +: 8];
        if (exp_w.exists(a + 4*i + k)) exp_w.delete(a + 4*i + k);
      end
  endtask

  function automatic bit usable(input int unsigned a);
    bit [31:0] st, s2;
    st = view_rd(a);
    s2 = view_rd(a + 4);
    return st[31] && (s2[10:0] >= 11'd64);
  endfunction

  task automatic exp_word(input int unsigned a, input bit [31:0] w);
    for (int k = 0; k < 4; k++) exp_w[a + k] = w[8*k +: 8];
    e_wrb += 4;
  endtask

  // behavioural reference for one frame
  task automatic model_frame(input int len, input bit en);
    int unsigned a, nx;
    int left, pos, take, rep, size, guard;
    bit first, last, found;
    bit [31:0] s2, bp;
    e_rx = 0; e_nb = 0; e_dc = 0; e_wrb = 0;
    if (!en) return;
    e_dc = 1;
    if (m_cur == 0) begin e_nb = 1; return; end
    a = m_cur; found = 0;
    for (guard = 0; guard < 32; guard++) begin
      if (usable(a)) begin found = 1; break; end
      nx = view_rd(a + 12);
      if (nx == m_cur || nx == 0) break;
      a = nx;
    end
    if (!found) begin e_nb = 1; return; end
    m_cur = a; left = len; pos = 0; first = 1;
    forever begin
      s2 = view_rd(a + 4); bp = view_rd(a + 8); nx = view_rd(a + 12);
      size = int'(s2[10:0]);
      if (size < left + 4) begin
        take = (size < left) ? size : left; rep = size; last = 0;
      end else begin
        take = left; rep = left + 4 + ((left < 64) ? 64 - left : 0); last = 1;
      end
      for (int k = 0; k < take; k++) begin exp_w[bp + k] = fb[pos + k]; e_wrb++; end
      exp_word(a, {2'b00, 14'(rep), 6'h0, first, last, 8'h0});
      if (!s2[31]) e_rx++;
      pos += take; left -= take; first = 0;
      if (nx == 0 || !usable(nx)) begin e_nb = 1; m_cur = m_head; return; end
      a = nx; m_cur = a;
      if (left == 0) return;
    end
  endtask

  task automatic set_head(input int unsigned a);
    @(negedge clk); head_wr = 1'b1; head_addr = a;
    @(negedge clk); head_wr = 1'b0;
    check(cur_desc_ptr == a, "R1", "cur after head load", cur_desc_ptr, a);
    m_head = a; m_cur = a;
  endtask

  task automatic send_frame(input string tag, input int len, input int seed, input bit en);
    int i;
    fb.delete();
    for (int k = 0; k < len; k++) fb.push_back(8'(seed + 7 * k));
    model_frame(len, en);
    @(negedge clk);
    rx_en = en; n_req = 0; n_rx = 0; n_nb = 0; n_dc = 0; n_wrb = 0;
    i = 0;
    while (i < len) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_sof = (i == 0); frm_len = LEN_W'(len); frm_data = fb[i];
      #1;
      if (frm_ready) i++;
    end
    @(negedge clk); frm_valid = 1'b0; frm_sof = 1'b0;
    repeat (40) @(negedge clk);
    check(n_rx == e_rx, tag, "receive events (R6)", n_rx, e_rx);
    check(n_nb == e_nb, tag, "no-buffer events (R3/R7)", n_nb, e_nb);
    check(n_dc == e_dc, tag, "dma-start clears (R8)", n_dc, e_dc);
    check(cur_desc_ptr == m_cur, tag, "current pointer (R9)", cur_desc_ptr, m_cur);
    check(n_wrb == e_wrb, tag, "bytes written (R4/R5)", n_wrb, e_wrb);
    if (!en) check(n_req == 0, "R2", "memory accesses while disabled", n_req, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; head_wr = 1'b0; head_addr = '0;
    frm_valid = 1'b0; frm_sof = 1'b0; frm_len = '0; frm_data = '0; mem_rdata = '0;
    m_head = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    check(cur_desc_ptr == 0 && !frm_ready && !mem_req, "R1", "reset state", cur_desc_ptr, 0);
    check(!int_rx_set && !int_nobuf_set && !dma_start_clr, "R8", "reset events", 1, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: no head loaded, pointer 0
    send_frame("R3", 10, 8'h11, 1'b1);
    // R1, R2: head load then a disabled frame
    set_head(32'h100);
    put_desc(32'h100, 1, 100, 0, 32'h1000, 32'h110);
    put_desc(32'h110, 1, 200, 0, 32'h2000, 32'h120);
    put_desc(32'h120, 1,  64, 0, 32'h3000, 32'h130);
    put_desc(32'h130, 0,  64, 0, 32'h4000, 32'h100);
    send_frame("R2", 20, 8'h22, 1'b0);
    // R4/R5: short frame padded to 64, first and last in one descriptor
    send_frame("R4", 30, 8'h33, 1'b1);
    // R7: chain runs dry mid-frame
    send_frame("R7", 300, 8'h44, 1'b1);
    // R6/R9: two-descriptor frame, second suppresses the receive event
    put_desc(32'h100, 1,  64, 0, 32'h1000, 32'h110);
    put_desc(32'h110, 1, 100, 1, 32'h2000, 32'h120);
    put_desc(32'h120, 1, 200, 0, 32'h3000, 32'h130);
    put_desc(32'h130, 1,  64, 0, 32'h4000, 32'h100);
    send_frame("R6", 130, 8'h55, 1'b1);
    // R4 boundary: size 200 vs 197 bytes, no last flag
    send_frame("R4", 197, 8'h66, 1'b1);
    // R7: buffer exactly full, next descriptor already consumed
    send_frame("R7", 64, 8'h77, 1'b1);
    // R3: search skips a small and an unowned entry
    put_desc(32'h100, 1,  32, 0, 32'h1000, 32'h110);
    put_desc(32'h110, 0, 100, 0, 32'h2000, 32'h120);
    put_desc(32'h120, 1, 128, 0, 32'h3000, 32'h130);
    put_desc(32'h130, 0,  64, 0, 32'h4000, 32'h100);
    send_frame("R3", 60, 8'h88, 1'b1);
    // R3: search wraps to its start without a usable entry
    send_frame("R3", 40, 8'h99, 1'b1);
    // R2: disabled frame leaves pointer alone
    send_frame("R2", 5, 8'haa, 1'b0);
    // R7: null link after the last descriptor
    set_head(32'h200);
    put_desc(32'h200, 1, 100, 0, 32'h5000, 32'h0);
    send_frame("R7", 10, 8'hbb, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule